// File: doc/BRIEF.md
# Two-Level Cache Inclusion Controller

This block tracks which block tags sit in a small first-level store and a larger second-level store, and moves tags between them according to a selectable inclusion policy. The policy can be inclusive, exclusive or non-inclusive non-exclusive. Both levels hold tags only and are fully associative. Each level replaces its oldest entry first.

A request carries one tag. The block looks the tag up in both levels in the cycle it accepts the request. It updates both stores at the same clock edge. In the following cycle it raises `done` together with one strobe for each action it took: fetch from memory, copy from the second level to the first, push the displaced first-level entry into the second level, evict from the second level, and invalidate the first-level copy of a tag that the second level evicted. Data movement is left to the surrounding logic, which follows these strobes.

Top module: `cache_incl_ctrl`

## Requirements
- R1: A request is accepted only when `busy` is low. `done` and `busy` are high for exactly the one cycle after acceptance. A request presented while `busy` is high is ignored.
- R2: When the tag is present in the first level, no store content changes and only `hit_l1` (plus `hit_l2` if the tag is also in the second level) is reported.
- R3: Inclusive policy, tag only in the second level: `l2_to_l1` is raised. The tag enters the first level, and the first-level victim is discarded without entering the second level. The second level is unchanged.
- R4: Inclusive policy, tag in neither level: `mem_fetch` is raised and the tag is installed in both levels.
- R5: Inclusive policy: when an insertion overflows the second level, `l2_evict` is raised with `evict_tag` set to the oldest second-level tag. If the first level holds that tag, it is removed from the first level and `back_inval` is raised. This removal is applied before the first-level fill.
- R6: Exclusive policy, tag only in the second level: `l2_to_l1` is raised and the tag leaves the second level. If the first level is full, its oldest tag moves into the second level, with `victim_to_l2` raised and `victim_tag` set to that tag.
- R7: Exclusive policy, tag in neither level: `mem_fetch` is raised and only the first level receives the tag. A displaced first-level tag goes to the second level as in R6.
- R8: Under the exclusive and non-inclusive non-exclusive policies, a second-level eviction raises `l2_evict` but never `back_inval`, and the first level keeps the evicted tag.
- R9: Non-inclusive non-exclusive policy fills exactly as R3 and R4 do.
- R10: Each level replaces its oldest entry when full. Entries that were removed do not count toward occupancy.
- R11: After reset both levels are empty and `busy`, `done` and all strobes are low.
- R12: The `policy` encoding is 0 for inclusive, 1 for exclusive, and 2 or 3 for non-inclusive non-exclusive. It is sampled with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| policy | input | 2 | Inclusion policy, sampled with the request |
| req_valid | input | 1 | Request strobe |
| req_tag | input | TAG_W | Tag of the requested block |
| busy | output | 1 | Request in progress; new requests ignored |
| done | output | 1 | Result cycle; strobes below are valid |
| hit_l1 | output | 1 | Tag was in the first level |
| hit_l2 | output | 1 | Tag was in the second level |
| mem_fetch | output | 1 | Block must be read from memory |
| l2_to_l1 | output | 1 | Block is supplied by the second level |
| victim_to_l2 | output | 1 | First-level victim placed in the second level |
| victim_tag | output | TAG_W | Tag of that victim |
| l2_evict | output | 1 | Second level evicted its oldest tag |
| evict_tag | output | TAG_W | Tag evicted from the second level |
| back_inval | output | 1 | First-level copy of the evicted tag was invalidated |

## Verification
The hardest case to reach is a back-invalidation that hits a tag which is still in the first level. The evicted second-level tag must be the oldest entry there while remaining one of the two newest first-level entries. The stimulus gets there by first filling the second level through misses. It then re-fetches the oldest tag through an second-level-only hit, which refreshes only the first level, and follows with one more miss. The exclusive sequence produces the mirror situation: a second-level hit while the second level is full must remove one entry and add one without evicting. Later hit and miss results at the ports then expose the resulting contents.

// File: rtl/cic_pkg.sv
package cic_pkg;

  typedef enum logic [1:0] {
    POL_INCL   = 2'd0,
    POL_EXCL   = 2'd1,
    POL_NINE   = 2'd2,
    POL_NINE_B = 2'd3
  } pol_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RESP = 1'b1
  } st_e;

  typedef struct packed {
    logic hit_l1;
    logic hit_l2;
    logic mem_fetch;
    logic l2_to_l1;
    logic victim_to_l2;
    logic l2_evict;
    logic back_inval;
  } act_t;

endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/cic_tag_fifo.sv
module cic_tag_fifo #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             rm_en,
  input  logic [TAG_W-1:0] rm_tag,
  output logic             rm_hit,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  output logic             full,
  output logic [TAG_W-1:0] head_tag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [TAG_W-1:0] cmp_tag [DEPTH];
  logic [TAG_W-1:0] nxt_tag [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    nxt_cnt;
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] lk_m;
  logic [DEPTH-1:0] rm_m;

  // occupancy and per-entry match vectors
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign vld[g]  = (CW'(g) < cnt_q);
    assign lk_m[g] = vld[g] && (tag_q[g] == lk_tag);
    assign rm_m[g] = vld[g] && (tag_q[g] == rm_tag);
  end

  assign lk_hit   = |lk_m;
  assign rm_hit   = |rm_m;
  assign full     = (cnt_q == CW'(DEPTH));
  assign head_tag = tag_q[0];

  // removal compacts toward the head, insertion appends at the tail
  always_comb begin
    int k;
    k       = 0;
    cmp_tag = tag_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !(rm_en && rm_m[i])) begin
        cmp_tag[k] = tag_q[i];
        k++;
      end
    end
    nxt_tag = cmp_tag;
    nxt_cnt = CW'(k);
    if (ins_en) begin
      if (k == DEPTH) begin
        for (int i = 0; i < DEPTH - 1; i++) nxt_tag[i] = cmp_tag[i+1];
        nxt_tag[DEPTH-1] = ins_tag;
      end else begin
        nxt_tag[k] = ins_tag;
        nxt_cnt    = CW'(k + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (upd_en) cnt_q <= nxt_cnt;
  end

  always_ff @(posedge clk) begin
    if (upd_en) tag_q <= nxt_tag;
  end
endmodule

// File: rtl/cic_decide.sv
module cic_decide
  import cic_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  pol_e             pol,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             l1_hit,
  input  logic             l1_full,
  input  logic [TAG_W-1:0] l1_head,
  input  logic             l1_rm_hit,
  input  logic             l2_hit,
  input  logic             l2_full,
  input  logic [TAG_W-1:0] l2_head,
  input  logic             l2_rm_hit,
  output logic             l1_ins_en,
  output logic [TAG_W-1:0] l1_ins_tag,
  output logic             l1_rm_en,
  output logic [TAG_W-1:0] l1_rm_tag,
  output logic             l2_ins_en,
  output logic [TAG_W-1:0] l2_ins_tag,
  output logic             l2_rm_en,
  output logic [TAG_W-1:0] l2_rm_tag,
  output act_t             act,
  output logic [TAG_W-1:0] victim_tag,
  output logic [TAG_W-1:0] evict_tag
);
  logic is_incl, is_excl, miss_l1, push_vic, l2_ovf;

  assign is_incl = (pol == POL_INCL);
  assign is_excl = (pol == POL_EXCL);
  assign miss_l1 = !l1_hit;

  // first level always fills on a miss
  assign l1_ins_en  = miss_l1;
  assign l1_ins_tag = req_tag;

  // exclusive policy keeps the displaced first-level tag
  assign push_vic   = is_excl && miss_l1 && l1_full;
  assign victim_tag = l1_head;

  always_comb begin
    if (is_excl) begin
      l2_ins_en  = push_vic;
      l2_ins_tag = l1_head;
      l2_rm_en   = miss_l1 && l2_hit;
    end else begin
      l2_ins_en  = miss_l1 && !l2_hit;
      l2_ins_tag = req_tag;
      l2_rm_en   = 1'b0;
    end
  end
  assign l2_rm_tag = req_tag;

  // overflow only when nothing was freed by a removal in the same step
  assign l2_ovf    = l2_ins_en && l2_full && !(l2_rm_en && l2_rm_hit);
  assign evict_tag = l2_head;

  // back-invalidation exists only under the inclusive policy
  assign l1_rm_en  = is_incl && l2_ovf;
  assign l1_rm_tag = l2_head;

  always_comb begin
    act.hit_l1       = l1_hit;
    act.hit_l2       = l2_hit;
    act.mem_fetch    = miss_l1 && !l2_hit;
    act.l2_to_l1     = miss_l1 && l2_hit;
    act.victim_to_l2 = push_vic;
    act.l2_evict     = l2_ovf;
    act.back_inval   = l1_rm_en && l1_rm_hit;
  end
endmodule

// File: rtl/cache_incl_ctrl.sv
module cache_incl_ctrl
  import cic_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int L1_WAYS = 2,
  parameter int L2_WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  output logic             busy,
  output logic             done,
  output logic             hit_l1,
  output logic             hit_l2,
  output logic             mem_fetch,
  output logic             l2_to_l1,
  output logic             victim_to_l2,
  output logic [TAG_W-1:0] victim_tag,
  output logic             l2_evict,
  output logic [TAG_W-1:0] evict_tag,
  output logic             back_inval
);
  logic             rst_q_n;
  st_e              st_q, st_d;
  logic             accept;
  act_t             act_d, act_q;
  logic [TAG_W-1:0] vtag_d, vtag_q, etag_d, etag_q;

  logic             l1_hit, l1_full, l1_rm_hit, l1_ins_en, l1_rm_en;
  logic [TAG_W-1:0] l1_head, l1_ins_tag, l1_rm_tag;
  logic             l2_hit, l2_full, l2_rm_hit, l2_ins_en, l2_rm_en;
  logic [TAG_W-1:0] l2_head, l2_ins_tag, l2_rm_tag;

  cic_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign accept = req_valid && (st_q == ST_IDLE);

  cic_tag_fifo #(.DEPTH(L1_WAYS), .TAG_W(TAG_W)) u_l1 (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .upd_en   (accept),
    .lk_tag   (req_tag),
    .lk_hit   (l1_hit),
    .rm_en    (l1_rm_en),
    .rm_tag   (l1_rm_tag),
    .rm_hit   (l1_rm_hit),
    .ins_en   (l1_ins_en),
    .ins_tag  (l1_ins_tag),
    .full     (l1_full),
    .head_tag (l1_head)
  );

  cic_tag_fifo #(.DEPTH(L2_WAYS), .TAG_W(TAG_W)) u_l2 (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .upd_en   (accept),
    .lk_tag   (req_tag),
    .lk_hit   (l2_hit),
    .rm_en    (l2_rm_en),
    .rm_tag   (l2_rm_tag),
    .rm_hit   (l2_rm_hit),
    .ins_en   (l2_ins_en),
    .ins_tag  (l2_ins_tag),
    .full     (l2_full),
    .head_tag (l2_head)
  );

  cic_decide #(.TAG_W(TAG_W)) u_dec (
    .pol        (pol_e'(policy)),
    .req_tag    (req_tag),
    .l1_hit     (l1_hit),
    .l1_full    (l1_full),
    .l1_head    (l1_head),
    .l1_rm_hit  (l1_rm_hit),
    .l2_hit     (l2_hit),
    .l2_full    (l2_full),
    .l2_head    (l2_head),
    .l2_rm_hit  (l2_rm_hit),
    .l1_ins_en  (l1_ins_en),
    .l1_ins_tag (l1_ins_tag),
    .l1_rm_en   (l1_rm_en),
    .l1_rm_tag  (l1_rm_tag),
    .l2_ins_en  (l2_ins_en),
    .l2_ins_tag (l2_ins_tag),
    .l2_rm_en   (l2_rm_en),
    .l2_rm_tag  (l2_rm_tag),
    .act        (act_d),
    .victim_tag (vtag_d),
    .evict_tag  (etag_d)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_RESP;
      default: st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  // result registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) act_q <= '0;
    else if (accept) act_q <= act_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      vtag_q <= vtag_d;
      etag_q <= etag_d;
    end
  end

  assign busy         = (st_q == ST_RESP);
  assign done         = busy;
  assign hit_l1       = done && act_q.hit_l1;
  assign hit_l2       = done && act_q.hit_l2;
  assign mem_fetch    = done && act_q.mem_fetch;
  assign l2_to_l1     = done && act_q.l2_to_l1;
  assign victim_to_l2 = done && act_q.victim_to_l2;
  assign l2_evict     = done && act_q.l2_evict;
  assign back_inval   = done && act_q.back_inval;
  assign victim_tag   = vtag_q;
  assign evict_tag    = etag_q;
endmodule

// File: rtl/cic_chk.sv
module cic_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] policy,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       hit_l1,
  input logic       hit_l2,
  input logic       mem_fetch,
  input logic       l2_to_l1,
  input logic       victim_to_l2,
  input logic       l2_evict,
  input logic       back_inval
);
  // R1
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> done);

  // R1
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && !busy));

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  l1_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_l1 |-> !(mem_fetch || l2_to_l1 || victim_to_l2 || l2_evict));

  // R4
  fetch_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fetch |-> (!hit_l1 && !hit_l2));

  // R3
  l2_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_to_l1 |-> (hit_l2 && !hit_l1));

  // R5
  binv_needs_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    back_inval |-> l2_evict);

  // R8
  binv_incl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    back_inval |-> ($past(policy) == 2'd0));

  // R11
  strobe_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_l1 || hit_l2 || mem_fetch || l2_to_l1 || victim_to_l2 || l2_evict || back_inval) |-> done);
endmodule

bind cache_incl_ctrl cic_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .policy       (policy),
  .req_valid    (req_valid),
  .busy         (busy),
  .done         (done),
  .hit_l1       (hit_l1),
  .hit_l2       (hit_l2),
  .mem_fetch    (mem_fetch),
  .l2_to_l1     (l2_to_l1),
  .victim_to_l2 (victim_to_l2),
  .l2_evict     (l2_evict),
  .back_inval   (back_inval)
);

// File: tb/cache_incl_ctrl_tb.sv
module cache_incl_ctrl_tb;
  localparam int TAG_W = 8;
  localparam int NV    = 27;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       policy = 2'd0;
  logic             req_valid = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             busy, done, hit_l1, hit_l2, mem_fetch, l2_to_l1;
  logic             victim_to_l2, l2_evict, back_inval;
  logic [TAG_W-1:0] victim_tag, evict_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cache_incl_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .req_valid(req_valid),
    .req_tag(req_tag), .busy(busy), .done(done), .hit_l1(hit_l1),
    .hit_l2(hit_l2), .mem_fetch(mem_fetch), .l2_to_l1(l2_to_l1),
    .victim_to_l2(victim_to_l2), .victim_tag(victim_tag),
    .l2_evict(l2_evict), .evict_tag(evict_tag), .back_inval(back_inval)
  );

  // {reset_first, policy, tag, {hl1,hl2,fetch,copy,vic,evict,binv}, victim, evicted}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'hA1, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'hA2, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'hA1, 7'b1100000, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'hA3, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'hA1, 7'b0101000, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'hA4, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'hA5, 7'b0010011, 8'h00, 8'hA1},
    {1'b0, 2'd0, 8'hA1, 7'b0010010, 8'h00, 8'hA2},
    {1'b0, 2'd0, 8'hA5, 7'b1100000, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'hB1, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'hB2, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'hB3, 7'b0010100, 8'hB1, 8'h00},
    {1'b0, 2'd1, 8'hB1, 7'b0101100, 8'hB2, 8'h00},
    {1'b0, 2'd1, 8'hB1, 7'b1000000, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'hB4, 7'b0010100, 8'hB3, 8'h00},
    {1'b0, 2'd1, 8'hB5, 7'b0010100, 8'hB1, 8'h00},
    {1'b0, 2'd1, 8'hB6, 7'b0010100, 8'hB4, 8'h00},
    {1'b0, 2'd1, 8'hB7, 7'b0010110, 8'hB5, 8'hB2},
    {1'b0, 2'd1, 8'hB3, 7'b0101100, 8'hB6, 8'h00},
    {1'b0, 2'd1, 8'hB2, 7'b0010110, 8'hB7, 8'hB1},
    {1'b1, 2'd2, 8'hC1, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'hC2, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'hC3, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'hC4, 7'b0010000, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'hC1, 7'b0101000, 8'h00, 8'h00},
    {1'b0, 2'd3, 8'hC5, 7'b0010010, 8'h00, 8'hC1},
    {1'b0, 2'd2, 8'hC1, 7'b1000000, 8'h00, 8'h00}
  };

  function automatic logic [6:0] acts();
    return {hit_l1, hit_l2, mem_fetch, l2_to_l1, victim_to_l2, l2_evict, back_inval};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R11 outputs idle while held in reset
    check("R11 reset idle", {busy, done, acts()}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // present a request at a falling edge; result is sampled one cycle later
  task automatic do_req(input logic [1:0] pol, input logic [TAG_W-1:0] tg);
    @(negedge clk);
    policy = pol;
    req_tag = tg;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R11 idle after release", {busy, done, acts()}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [33:0] e;
      string lbl;
      e = VEC[v];
      if (e[33]) do_reset();
      case (e[32:31])
        2'd0:    lbl = "R2 R3 R4 R5 R10";
        2'd1:    lbl = "R2 R6 R7 R8 R10";
        default: lbl = "R2 R8 R9 R12";
      endcase
      do_req(e[32:31], e[30:23]);
      check("R1 done", {31'd0, done}, 32'd1);
      check(lbl, {25'd0, acts()}, {25'd0, e[22:16]});
      if (e[18]) check({lbl, " victim tag"}, {24'd0, victim_tag}, {24'd0, e[15:8]});
      if (e[17]) check({lbl, " evict tag"}, {24'd0, evict_tag}, {24'd0, e[7:0]});
    end

    // R1: request held while busy is ignored and done lasts one cycle
    do_reset();
    @(negedge clk);
    policy = 2'd0;
    req_tag = 8'hD1;
    req_valid = 1'b1;
    @(negedge clk);
    check("R1 busy in result cycle", {30'd0, busy, done}, 32'd3);
    req_tag = 8'hD2;
    @(negedge clk);
    check("R1 done one cycle", {31'd0, done}, 32'd0);
    req_valid = 1'b0;
    do_req(2'd0, 8'hD2);
    check("R1 busy request ignored", {25'd0, acts()}, {25'd0, 7'b0010000});
    do_req(2'd0, 8'hD1);
    check("R2 first request stored", {25'd0, acts()}, {25'd0, 7'b1100000});
    @(negedge clk);
    check("R1 done low when idle", {30'd0, busy, done}, 32'd0);

    // R11: reset empties both levels
    do_reset();
    do_req(2'd0, 8'hD1);
    check("R11 contents cleared", {25'd0, acts()}, {25'd0, 7'b0010000});

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule